// File: doc/BRIEF.md
# SPI Register and FIFO Access Slave

This block is the serial slave front end of a radio controller. A host drives a four-wire SPI bus: chip select, clock, data in and data out. Each transaction opens with a header byte. The header carries a read/write flag, a burst flag and a six-bit address. Depending on the address, the slave reaches one of four targets:

- the configuration registers,
- the read-only status registers,
- the command strobes,
- the transmit and receive byte FIFOs.

The register storage and the FIFO storage live outside the block. The block only issues one-cycle strobes for them, with an address, write data or a pop request, and takes read data back.

While the host shifts in the header and any write data, the slave shifts out a status byte. That byte holds a not-ready flag taken from the oscillator, a three-bit state code and a four-bit FIFO level. The level is clamped at 15 and reports free transmit space on writes and filled receive bytes on reads.

The bus is sampled by the system clock. The clock runs well above the serial clock. Data is taken on rising serial-clock edges and changed on falling ones (mode 0).

Top module: `spi_regfifo_slave`

## Requirements
- R1: Bits are shifted most significant first. Header bit 7 is read (1) or write (0), bit 6 is burst, and bits 5:0 are the address. A single write to an address from 0x00 to 0x2E writes the following data byte to that register with one write strobe.
- R2: The byte returned during a header is {not-ready, state[2:0], level[3:0]}. The level is min(free TX bytes, 15) when header bit 7 is 0, and min(filled RX bytes, 15) when it is 1.
- R3: While chip select is high the output enable is low. While it is low, the output shows the inverted oscillator-ready flag before the first clock edge, so it goes low once the oscillator is ready.
- R4: A single read of a configuration register returns that register's contents on the data byte. The byte after it is treated as a new header.
- R5: In a configuration burst the address rises by one after every data byte. Once 0x2E has been passed, no further strobes are issued and read bytes return 0x00.
- R6: Addresses 0x30 to 0x3D with the burst bit set give one read-only status register. A read returns its value for one data byte, and the next byte is a header. A write to that range produces no strobe.
- R7: Addresses 0x30 to 0x3D with the burst bit clear issue one command pulse, carrying the address, when the header completes. No data byte follows, and the next byte is again a header.
- R8: Address 0x3F pushes written bytes into the TX FIFO and pops read bytes from the RX FIFO. A single access moves one byte and a burst streams until chip select rises. Addresses 0x2F and 0x3E produce no strobe.
- R9: During each write data byte the returned byte is the status byte. Its level is the free TX space before that byte is stored, so the last byte that fits reports 1.
- R10: If chip select rises before a header or data byte is complete, that byte causes no strobe.
- R11: Write, read, command, push and pop strobes are one-cycle pulses, and at most one is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idle low |
| si_i | input | 1 | Serial data from host |
| so_o | output | 1 | Serial data to host |
| so_oe_o | output | 1 | Output enable for so_o (low means high impedance) |
| osc_ready_i | input | 1 | Oscillator running flag |
| state_i | input | 3 | Controller state code placed in the status byte |
| tx_free_i | input | CNT_W | Free bytes in the TX FIFO |
| rx_fill_i | input | CNT_W | Filled bytes in the RX FIFO |
| reg_addr_o | output | 6 | Address of the current strobe |
| reg_wdata_o | output | 8 | Write data for register write or FIFO push |
| reg_wr_o | output | 1 | Configuration register write strobe |
| reg_rd_o | output | 1 | Configuration or status register read strobe |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o, valid while reg_rd_o is high |
| cmd_o | output | 1 | Command strobe pulse |
| txf_push_o | output | 1 | TX FIFO push strobe |
| rxf_pop_o | output | 1 | RX FIFO pop strobe |
| rxf_data_i | input | 8 | Head byte of the RX FIFO (show-ahead) |

## Verification
The assertions assume three things about the inputs. First, chip select and the serial clock are already synchronous to the system clock. Second, each serial-clock level lasts several system cycles. Third, reg_rdata_i is valid for reg_addr_o in the cycle the read strobe is high.

The stimulus keeps within these limits. Every pin is driven on the falling system-clock edge, and each serial half period lasts four system cycles. The register model answers combinationally from the presented address. The FIFO levels are derived from counted push and pop strobes, so they move exactly one cycle after each strobe.

// File: rtl/spi_acc_pkg.sv
package spi_acc_pkg;
    localparam int ADDR_W = 6;
    localparam int BYTE_W = 8;
    localparam logic [ADDR_W-1:0] CFG_LAST   = 6'h2E;
    localparam logic [ADDR_W-1:0] STAT_FIRST = 6'h30;
    localparam logic [ADDR_W-1:0] STAT_LAST  = 6'h3D;
    localparam logic [ADDR_W-1:0] FIFO_ADDR  = 6'h3F;

    typedef enum logic [1:0] {
        K_CFG  = 2'd0,
        K_STAT = 2'd1,
        K_FIFO = 2'd2,
        K_NONE = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/spi_edge_det.sv
module spi_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
    assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/spi_hdr_decode.sv
module spi_hdr_decode
    import spi_acc_pkg::*;
(
    input  logic [BYTE_W-1:0] hdr_i,
    output logic              rw_o,
    output logic              burst_o,
    output logic [ADDR_W-1:0] addr_o,
    output acc_kind_e         kind_o,
    output logic              is_cmd_o
);
    always_comb begin
        rw_o     = hdr_i[7];
        burst_o  = hdr_i[6];
        addr_o   = hdr_i[ADDR_W-1:0];
        is_cmd_o = 1'b0;
        kind_o   = K_NONE;
        if (addr_o <= CFG_LAST) begin
            kind_o = K_CFG;
        end else if (addr_o == FIFO_ADDR) begin
            kind_o = K_FIFO;
        end else if (addr_o >= STAT_FIRST && addr_o <= STAT_LAST) begin
            kind_o   = burst_o ? K_STAT : K_NONE;
            is_cmd_o = ~burst_o;
        end
    end
endmodule

// File: rtl/spi_status_fmt.sv
module spi_status_fmt #(
    parameter int CNT_W = 7
) (
    input  logic             ready_i,
    input  logic [2:0]       state_i,
    input  logic [CNT_W-1:0] tx_free_i,
    input  logic [CNT_W-1:0] rx_fill_i,
    input  logic             sel_rx_i,
    output logic [7:0]       status_o
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(15);

    logic [CNT_W-1:0] level;
    logic [3:0]       level_sat;

    always_comb begin
        level     = sel_rx_i ? rx_fill_i : tx_free_i;
        level_sat = (level > SAT) ? 4'hF : level[3:0];
        status_o  = {~ready_i, state_i, level_sat};
    end
endmodule

// File: rtl/spi_regfifo_slave.sv
module spi_regfifo_slave
    import spi_acc_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_i,
    input  logic              sclk_i,
    input  logic              si_i,
    output logic              so_o,
    output logic              so_oe_o,
    input  logic              osc_ready_i,
    input  logic [2:0]        state_i,
    input  logic [CNT_W-1:0]  tx_free_i,
    input  logic [CNT_W-1:0]  rx_fill_i,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    input  logic [BYTE_W-1:0] reg_rdata_i,
    output logic              cmd_o,
    output logic              txf_push_o,
    output logic              rxf_pop_o,
    input  logic [BYTE_W-1:0] rxf_data_i
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              hdr_phase;
        logic [BIT_W-1:0]  rcnt;
        logic [BIT_W-1:0]  fcnt;
        logic [BYTE_W-2:0] shf;
        logic              rw;
        logic              burst;
        logic [ADDR_W-1:0] addr;
        acc_kind_e         kind;
        logic              over;
        logic              out_live;
        logic [BYTE_W-1:0] out_sr;
        logic              wr;
        logic              rd;
        logic              cmd;
        logic              push;
        logic              pop;
        logic [ADDR_W-1:0] s_addr;
        logic [BYTE_W-1:0] wdata;
    } st_t;

    localparam st_t ST_RST = '{hdr_phase: 1'b1, out_live: 1'b1, kind: K_CFG, default: '0};

    st_t q, d;

    logic              rise, fall;
    logic [BYTE_W-1:0] byte_in;
    logic [BYTE_W-1:0] status_byte;
    logic              dec_rw, dec_burst, dec_cmd;
    logic [ADDR_W-1:0] dec_addr;
    acc_kind_e         dec_kind;

    spi_edge_det u_sclk_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sclk_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign byte_in = {q.shf, si_i};

    spi_hdr_decode u_hdr (
        .hdr_i    (byte_in),
        .rw_o     (dec_rw),
        .burst_o  (dec_burst),
        .addr_o   (dec_addr),
        .kind_o   (dec_kind),
        .is_cmd_o (dec_cmd)
    );

    spi_status_fmt #(.CNT_W(CNT_W)) u_status (
        .ready_i   (osc_ready_i),
        .state_i   (state_i),
        .tx_free_i (tx_free_i),
        .rx_fill_i (rx_fill_i),
        .sel_rx_i  (q.rw),
        .status_o  (status_byte)
    );

    always_comb begin
        d      = q;
        d.wr   = 1'b0;
        d.rd   = 1'b0;
        d.cmd  = 1'b0;
        d.push = 1'b0;
        d.pop  = 1'b0;
        if (csn_i) begin
            d.hdr_phase = 1'b1;
            d.rcnt      = '0;
            d.fcnt      = '0;
            d.out_live  = 1'b1;
            d.over      = 1'b0;
        end else begin
            if (rise) begin
                d.rcnt = q.rcnt + 1'b1;
                d.shf  = byte_in[BYTE_W-2:0];
                if (q.hdr_phase && q.rcnt == '0) d.rw = si_i;
                if (q.rcnt == LAST_BIT) begin
                    if (q.hdr_phase) begin
                        d.rw    = dec_rw;
                        d.burst = dec_burst;
                        d.addr  = dec_addr;
                        d.kind  = dec_kind;
                        d.over  = 1'b0;
                        if (dec_cmd) begin
                            d.cmd    = 1'b1;
                            d.s_addr = dec_addr;
                        end else begin
                            d.hdr_phase = 1'b0;
                        end
                    end else begin
                        if (!q.rw) begin
                            if (q.kind == K_CFG && !q.over) begin
                                d.wr     = 1'b1;
                                d.s_addr = q.addr;
                                d.wdata  = byte_in;
                            end else if (q.kind == K_FIFO) begin
                                d.push   = 1'b1;
                                d.s_addr = q.addr;
                                d.wdata  = byte_in;
                            end
                        end else if (q.kind == K_FIFO) begin
                            d.pop    = 1'b1;
                            d.s_addr = q.addr;
                        end
                        if (q.burst && q.kind == K_CFG) begin
                            if (q.addr == CFG_LAST) d.over = 1'b1;
                            else                    d.addr = q.addr + 1'b1;
                        end
                        d.hdr_phase = !(q.burst && (q.kind == K_CFG || q.kind == K_FIFO));
                    end
                end
            end
            if (fall) begin
                d.fcnt = q.fcnt + 1'b1;
                if (q.fcnt == LAST_BIT) begin
                    if (q.hdr_phase) begin
                        d.out_live = 1'b1;
                    end else begin
                        d.out_live = 1'b0;
                        if (!q.rw) begin
                            d.out_sr = status_byte;
                        end else if (q.kind == K_FIFO) begin
                            d.out_sr = rxf_data_i;
                        end else begin
                            d.out_sr = '0;
                            if ((q.kind == K_CFG && !q.over) || q.kind == K_STAT) begin
                                d.rd     = 1'b1;
                                d.s_addr = q.addr;
                            end
                        end
                    end
                end
            end
        end
        if (q.rd) d.out_sr = reg_rdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ST_RST;
        else        q <= d;
    end

    assign so_oe_o     = ~csn_i;
    assign so_o        = csn_i ? 1'b0 : (q.out_live ? status_byte[~q.fcnt] : q.out_sr[~q.fcnt]);
    assign reg_addr_o  = q.s_addr;
    assign reg_wdata_o = q.wdata;
    assign reg_wr_o    = q.wr;
    assign reg_rd_o    = q.rd;
    assign cmd_o       = q.cmd;
    assign txf_push_o  = q.push;
    assign rxf_pop_o   = q.pop;

    // R11: strobes never overlap
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_o, reg_rd_o, cmd_o, txf_push_o, rxf_pop_o}));

    // R10: a deselected bus yields no strobe in the following cycle
    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        csn_i |=> !(reg_wr_o | reg_rd_o | cmd_o | txf_push_o | rxf_pop_o));

    // R5: register writes only land in the configuration range
    a_r5_wr_in_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> reg_addr_o <= CFG_LAST);

    // R6: reads target configuration or status registers only
    a_r6_rd_range: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |-> (reg_addr_o <= CFG_LAST ||
                      (reg_addr_o >= STAT_FIRST && reg_addr_o <= STAT_LAST)));

    // R7: command pulses carry a strobe address
    a_r7_cmd_range: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o |-> (reg_addr_o >= STAT_FIRST && reg_addr_o <= STAT_LAST));

    // R8: FIFO strobes carry the FIFO address
    a_r8_fifo_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (txf_push_o | rxf_pop_o) |-> reg_addr_o == FIFO_ADDR);

    // R11: each strobe is a single-cycle pulse
    a_r11_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o |=> !cmd_o);
endmodule

// File: tb/spi_regfifo_slave_bench.sv
module spi_regfifo_slave_bench;
    localparam int CNT_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic csn = 1'b1, sclk = 1'b0, si = 1'b0;
    logic so, so_oe, osc_ready = 1'b1;
    logic [2:0] state = 3'b010;
    logic [CNT_W-1:0] tx_free, rx_fill;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata, rxf_data;
    logic reg_wr, reg_rd, cmd, push, pop;

    spi_regfifo_slave #(.CNT_W(CNT_W)) u_spi_regfifo_slave (
        .clk(clk), .rst_n(rst_n), .csn_i(csn), .sclk_i(sclk), .si_i(si),
        .so_o(so), .so_oe_o(so_oe), .osc_ready_i(osc_ready), .state_i(state),
        .tx_free_i(tx_free), .rx_fill_i(rx_fill), .reg_addr_o(reg_addr),
        .reg_wdata_o(reg_wdata), .reg_wr_o(reg_wr), .reg_rd_o(reg_rd),
        .reg_rdata_i(reg_rdata), .cmd_o(cmd), .txf_push_o(push),
        .rxf_pop_o(pop), .rxf_data_i(rxf_data)
    );

    // models of the surrounding storage
    logic [7:0] mem [0:63];
    logic [7:0] rx_data [0:31];
    logic [7:0] push_log [0:15];
    logic [7:0] tx_base = 8'd0, rx_base = 8'd0;
    logic [7:0] push_cnt, pop_cnt;
    int wr_n, rd_n, cmd_n, multi_n;
    logic [5:0] last_cmd;

    assign tx_free   = CNT_W'(tx_base - push_cnt);
    assign rx_fill   = CNT_W'(rx_base - pop_cnt);
    assign rxf_data  = rx_data[pop_cnt[4:0]];
    assign reg_rdata = (reg_addr < 6'h30) ? mem[reg_addr] : {2'b10, reg_addr};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 3 + 1);
            push_cnt <= '0; pop_cnt <= '0;
            wr_n <= 0; rd_n <= 0; cmd_n <= 0; multi_n <= 0; last_cmd <= '0;
        end else begin
            if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_n <= wr_n + 1; end
            if (reg_rd) rd_n <= rd_n + 1;
            if (cmd) begin cmd_n <= cmd_n + 1; last_cmd <= reg_addr; end
            if (push) begin push_log[push_cnt[3:0]] <= reg_wdata; push_cnt <= push_cnt + 1'b1; end
            if (pop) pop_cnt <= pop_cnt + 1'b1;
            if ((32'(reg_wr) + 32'(reg_rd) + 32'(cmd) + 32'(push) + 32'(pop)) > 1)
                multi_n <= multi_n + 1;
        end
    end

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] stexp(input int lvl);
        return {1'b0, state, (lvl > 15) ? 4'hF : 4'(lvl)};
    endfunction

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - nb; i--) begin
            si = tx[i];
            wclk(4);
            rx[i] = so;
            sclk = 1'b1;
            wclk(4);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_lo();
        csn = 1'b0; wclk(4);
    endtask

    task automatic cs_hi();
        wclk(4); csn = 1'b1; wclk(6);
    endtask

    logic [7:0] b;
    int wr0, cmd0, p0;

    initial begin
        for (int i = 0; i < 32; i++) rx_data[i] = 8'h60 + 8'(i);
        wclk(5);
        rst_n = 1'b1;
        wclk(3);
        // reset state
        chk(so_oe == 1'b0, "R3 oe low at reset", so_oe, 0);
        chk({reg_wr, reg_rd, cmd, push, pop} == 5'b0, "R11 no strobe at reset",
            {reg_wr, reg_rd, cmd, push, pop}, 0);

        // R3: not-ready then ready on SO
        osc_ready = 1'b0;
        cs_lo();
        chk(so_oe == 1'b1, "R3 oe when selected", so_oe, 1);
        chk(so == 1'b1, "R3 so high while not ready", so, 1);
        osc_ready = 1'b1;
        wclk(2);
        chk(so == 1'b0, "R3 so low once ready", so, 0);
        cs_hi();
        chk(so_oe == 1'b0, "R3 oe low after deselect", so_oe, 0);

        // R2: level sweep with saturation
        for (int f = 0; f <= 20; f++) begin
            tx_base = 8'(f) + push_cnt;
            rx_base = 8'(20 - f) + pop_cnt;
            wclk(2);
            cs_lo(); xfer(8'h05, 8, b); cs_hi();
            chk(b == stexp(f), "R2 write header level", b, stexp(f));
            cs_lo(); xfer(8'h85, 8, b); cs_hi();
            chk(b == stexp(20 - f), "R2 read header level", b, stexp(20 - f));
        end
        chk(wr_n == 0, "R2 header alone writes nothing", wr_n, 0);

        // R2: not-ready flag in the header byte
        osc_ready = 1'b0;
        cs_lo(); xfer(8'h05, 8, b); cs_hi();
        chk(b[7] == 1'b1, "R2 not-ready bit", b[7], 1);
        osc_ready = 1'b1;

        // R1 / R9: single register write
        tx_base = 8'd9 + push_cnt;
        cs_lo(); xfer(8'h05, 8, b); xfer(8'hC3, 8, b); cs_hi();
        chk(b == stexp(9), "R9 status on write data", b, stexp(9));
        chk(wr_n == 1, "R1 one write strobe", wr_n, 1);
        chk(mem[5] == 8'hC3, "R1 register written", mem[5], 8'hC3);

        // R4: single read, next byte is a header
        rx_base = 8'd4 + pop_cnt;
        cs_lo();
        xfer(8'h85, 8, b);
        xfer(8'h00, 8, b);
        chk(b == 8'hC3, "R4 single read data", b, 8'hC3);
        xfer(8'h86, 8, b);
        chk(b == stexp(4), "R4 next byte is header", b, stexp(4));
        xfer(8'h00, 8, b);
        chk(b == 8'd19, "R4 second read data", b, 19);
        cs_hi();

        // R5: burst write crossing the end of the configuration range
        wr0 = wr_n;
        cs_lo(); xfer(8'h6C, 8, b);
        for (int k = 0; k < 5; k++) xfer(8'hA0 + 8'(k), 8, b);
        cs_hi();
        chk(wr_n - wr0 == 3, "R5 writes stop after last register", wr_n - wr0, 3);
        cs_lo(); xfer(8'hEC, 8, b);
        for (int k = 0; k < 5; k++) begin
            xfer(8'h00, 8, b);
            chk(b == ((k < 3) ? 8'hA0 + 8'(k) : 8'h00), "R5 burst read data", b,
                (k < 3) ? 8'hA0 + 8'(k) : 8'h00);
        end
        cs_hi();

        // R6: status register read then header
        cs_lo();
        xfer(8'hF5, 8, b);
        xfer(8'h00, 8, b);
        chk(b == 8'hB5, "R6 status register value", b, 8'hB5);
        xfer(8'h85, 8, b);
        xfer(8'h00, 8, b);
        chk(b == 8'hC3, "R6 header after status read", b, 8'hC3);
        cs_hi();
        wr0 = wr_n; cmd0 = cmd_n; p0 = 32'(push_cnt);
        cs_lo(); xfer(8'h75, 8, b); xfer(8'h11, 8, b); cs_hi();
        chk(wr_n == wr0 && cmd_n == cmd0 && 32'(push_cnt) == p0, "R6 write to status range ignored",
            wr_n - wr0, 0);

        // R8: reserved addresses produce nothing
        cs_lo(); xfer(8'h2F, 8, b); xfer(8'h55, 8, b); xfer(8'h3E, 8, b); xfer(8'h55, 8, b); cs_hi();
        chk(wr_n == wr0 && 32'(push_cnt) == p0, "R8 reserved addresses ignored", wr_n - wr0, 0);

        // R7: command strobe with no data byte
        cmd0 = cmd_n;
        cs_lo();
        xfer(8'h36, 8, b);
        xfer(8'h86, 8, b);
        xfer(8'h00, 8, b);
        cs_hi();
        chk(cmd_n - cmd0 == 1, "R7 one command pulse", cmd_n - cmd0, 1);
        chk(last_cmd == 6'h36, "R7 command address", last_cmd, 6'h36);
        chk(b == 8'd19, "R7 next byte is header", b, 19);

        // R8 / R9: TX FIFO burst down to the last free byte
        tx_base = 8'd3 + push_cnt;
        p0 = 32'(push_cnt);
        cs_lo();
        xfer(8'h7F, 8, b);
        chk(b == stexp(3), "R9 header level before push", b, stexp(3));
        for (int k = 0; k < 3; k++) begin
            xfer(8'h11 * 8'(k + 1), 8, b);
            chk(b == stexp(3 - k), "R9 free space before byte", b, stexp(3 - k));
        end
        cs_hi();
        chk(32'(push_cnt) - p0 == 3, "R8 burst push count", 32'(push_cnt) - p0, 3);
        chk(push_log[p0[3:0] + 4'd2] == 8'h33, "R8 pushed data", push_log[p0[3:0] + 4'd2], 8'h33);
        tx_base = 8'd8 + push_cnt;
        cs_lo(); xfer(8'h3F, 8, b); xfer(8'h44, 8, b); xfer(8'h85, 8, b); xfer(8'h00, 8, b); cs_hi();
        chk(32'(push_cnt) - p0 == 4, "R8 single push", 32'(push_cnt) - p0, 4);
        chk(b == 8'hC3, "R8 header after single push", b, 8'hC3);

        // R8: RX FIFO burst and single reads
        rx_base = 8'd5 + pop_cnt;
        p0 = 32'(pop_cnt);
        cs_lo();
        xfer(8'hFF, 8, b);
        chk(b == stexp(5), "R2 RX level in header", b, stexp(5));
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, 8, b);
            chk(b == 8'h60 + 8'(p0 + k), "R8 burst pop data", b, 8'h60 + 8'(p0 + k));
        end
        cs_hi();
        chk(32'(pop_cnt) - p0 == 3, "R8 burst pop count", 32'(pop_cnt) - p0, 3);
        cs_lo(); xfer(8'hBF, 8, b); xfer(8'h00, 8, b);
        chk(b == 8'h60 + 8'(p0 + 3), "R8 single pop data", b, 8'h60 + 8'(p0 + 3));
        xfer(8'h86, 8, b); xfer(8'h00, 8, b); cs_hi();
        chk(b == 8'd19, "R8 header after single pop", b, 19);
        chk(32'(pop_cnt) - p0 == 4, "R8 single pop count", 32'(pop_cnt) - p0, 4);

        // R10: cancelled data byte and cancelled header
        wr0 = wr_n; cmd0 = cmd_n;
        cs_lo(); xfer(8'h07, 8, b); xfer(8'hEE, 4, b); cs_hi();
        cs_lo(); xfer(8'h87, 8, b); xfer(8'h00, 8, b); cs_hi();
        chk(wr_n == wr0, "R10 partial data byte not written", wr_n - wr0, 0);
        chk(b == 8'd22, "R10 register unchanged", b, 22);
        cs_lo(); xfer(8'h36, 5, b); cs_hi();
        chk(cmd_n == cmd0, "R10 partial header no command", cmd_n - cmd0, 0);

        chk(multi_n == 0, "R11 overlapping strobes", multi_n, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule